// File: doc/BRIEF.md
# DAC Conversion Trigger Selector

This block decides the clock cycle in which a digital-to-analog converter begins a conversion. A configuration bit chooses between two regimes. With the bit clear, every write to the converter's data register starts a conversion. With the bit set, a source-select field picks exactly one hardware or software source: a software strobe, an external pin, one of several timer events or one of several PWM events. The external pin can be sensed by level or by edge, and a two-bit mode field chooses which.

The external pin is asynchronous to the block clock, so it passes through a flop synchroniser before any detection. The block watches a busy input from the converter. A trigger that arrives while the converter is busy, or in the cycle right after a start, is dropped and is not remembered. Because of this, a pin held at its active level in a level mode gives back-to-back conversions paced by the converter. The block's only output is a registered start pulse that lasts one cycle. Any change to the trigger configuration clears the pin edge history, so a reconfiguration can never produce an edge that was never seen under the new setting.

Top module: `dac_trig_sel`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, start_conv is 0.
- R2: With trig_en = 0, a dat_wr strobe sampled at a clock edge gives start_conv = 1 in the following cycle. sw_trig, ext_pin, tmr_evt and pwm_evt have no effect.
- R3: With trig_en = 1 and src_sel = 0, only a sw_trig strobe starts a conversion. It is a one-cycle request that holds no state, and dat_wr has no effect.
- R4: With trig_en = 1 and src_sel = 1, pin_mode 0 starts conversions while the synchronised pin is low, and pin_mode 1 starts them while it is high. A held active level repeats the start each time the block and the converter are free.
- R5: With src_sel = 1, pin_mode 2 starts one conversion per falling edge of the synchronised pin, and pin_mode 3 starts one per rising edge. A steady pin starts nothing.
- R6: src_sel values 2 to 5 select tmr_evt[0] to tmr_evt[3], and values 6 and 7 select pwm_evt[0] and pwm_evt[1]. Events that are not selected have no effect.
- R7: ext_pin passes through two synchronising flops. A rising edge on ext_pin in rising-edge mode, sampled at clock edge k, shows as start_conv = 1 after edge k+2 and not earlier.
- R8: A trigger sampled while conv_busy = 1 is dropped and is not started later.
- R9: start_conv is never 1 in two consecutive cycles.
- R10: In the first clock edge after trig_en, src_sel or pin_mode changes, edge detection is suppressed, so a pin transition that happened under the previous setting gives no start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_en | input | 1 | 0: convert on data write; 1: use the selected source |
| src_sel | input | SEL_W (3) | Source select: 0 software, 1 pin, 2..5 timers, 6..7 PWM |
| pin_mode | input | 2 | Pin sensing: 0 low, 1 high, 2 falling, 3 rising |
| ext_pin | input | 1 | External trigger pin, asynchronous |
| tmr_evt | input | N_TMR (4) | Timer event pulses |
| pwm_evt | input | N_PWM (2) | PWM event pulses |
| sw_trig | input | 1 | Software trigger strobe |
| dat_wr | input | 1 | Data register write strobe |
| conv_busy | input | 1 | Converter busy |
| start_conv | output | 1 | One-cycle start-conversion pulse |

## Verification
Every event source is pulsed under every src_sel value. This tells apart a correct source decode from swapped or overlapping indices, and it shows that unselected and disabled sources have no effect. The pin is held steady, toggled, and held at the active level under each pin_mode, which separates level sensing from edge sensing and each polarity from the other. Triggers are also timed to fall inside a busy window and inside the cycle right after a start, to show that dropped requests are not remembered. A reconfiguration is placed in the same cycle as a pending synchronised transition, and a single pin edge is timed to find the exact synchroniser latency.

// File: rtl/dts_pkg.sv
package dts_pkg;
   typedef enum logic [1:0] {
      PIN_LOW  = 2'd0,
      PIN_HIGH = 2'd1,
      PIN_FALL = 2'd2,
      PIN_RISE = 2'd3
   } pin_mode_e;

   localparam int SRC_SOFT = 0;
   localparam int SRC_PIN  = 1;
   localparam int SRC_TMR0 = 2;
endpackage

// File: rtl/dts_sync.sv
module dts_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_async,
   output logic q_sync
);
   logic [STAGES-1:0] chain;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain[0] <= 1'b0;
               else        chain[0] <= d_async;
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain[i] <= 1'b0;
               else        chain[i] <= chain[i-1];
         end
      end
   endgenerate

   assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/dts_edge.sv
module dts_edge #(
   parameter int CFG_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pin_s,
   input  logic [CFG_W-1:0] cfg,
   output logic             fall,
   output logic             rise
);
   logic             pin_prev;
   logic [CFG_W-1:0] cfg_q;
   logic             hist_ok;
   logic             edge_ok;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         pin_prev <= 1'b0;
         cfg_q    <= '0;
         hist_ok  <= 1'b0;
      end else begin
         pin_prev <= pin_s;
         cfg_q    <= cfg;
         hist_ok  <= 1'b1;
      end

   // history counts only when the setting was identical one edge ago
   assign edge_ok = hist_ok && (cfg == cfg_q);
   assign fall    = edge_ok &&  pin_prev && !pin_s;
   assign rise    = edge_ok && !pin_prev &&  pin_s;
endmodule

// File: rtl/dts_mux.sv
module dts_mux
   import dts_pkg::*;
#(
   parameter int N_TMR = 4,
   parameter int N_PWM = 2,
   parameter int SEL_W = 3
) (
   input  logic             trig_en,
   input  logic [SEL_W-1:0] src_sel,
   input  pin_mode_e        pin_mode,
   input  logic             pin_s,
   input  logic             pin_fall,
   input  logic             pin_rise,
   input  logic [N_TMR-1:0] tmr_evt,
   input  logic [N_PWM-1:0] pwm_evt,
   input  logic             sw_trig,
   input  logic             dat_wr,
   output logic             raw_trig
);
   localparam int PWM_BASE = SRC_TMR0 + N_TMR;

   logic pin_hit;
   logic tmr_hit;
   logic pwm_hit;

   always_comb begin
      unique case (pin_mode)
         PIN_LOW:  pin_hit = !pin_s;
         PIN_HIGH: pin_hit =  pin_s;
         PIN_FALL: pin_hit =  pin_fall;
         default:  pin_hit =  pin_rise;
      endcase
   end

   always_comb begin
      tmr_hit = 1'b0;
      for (int i = 0; i < N_TMR; i++)
         if (int'(src_sel) == SRC_TMR0 + i) tmr_hit = tmr_evt[i];
   end

   always_comb begin
      pwm_hit = 1'b0;
      for (int i = 0; i < N_PWM; i++)
         if (int'(src_sel) == PWM_BASE + i) pwm_hit = pwm_evt[i];
   end

   always_comb begin
      if (!trig_en)                        raw_trig = dat_wr;
      else if (int'(src_sel) == SRC_SOFT)  raw_trig = sw_trig;
      else if (int'(src_sel) == SRC_PIN)   raw_trig = pin_hit;
      else                                 raw_trig = tmr_hit | pwm_hit;
   end
endmodule

// File: rtl/dac_trig_sel.sv
module dac_trig_sel
   import dts_pkg::*;
#(
   parameter int N_TMR       = 4,
   parameter int N_PWM       = 2,
   parameter int SEL_W       = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             trig_en,
   input  logic [SEL_W-1:0] src_sel,
   input  logic [1:0]       pin_mode,
   input  logic             ext_pin,
   input  logic [N_TMR-1:0] tmr_evt,
   input  logic [N_PWM-1:0] pwm_evt,
   input  logic             sw_trig,
   input  logic             dat_wr,
   input  logic             conv_busy,
   output logic             start_conv
);
   localparam int N_SRC = SRC_TMR0 + N_TMR + N_PWM;
   localparam int CFG_W = 1 + SEL_W + 2;

   generate
      if (N_SRC > (1 << SEL_W)) begin : g_bad_sel
         $error("src_sel too narrow for the number of sources");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("synchroniser needs at least two stages");
      end
      if (N_TMR < 1 || N_PWM < 1) begin : g_bad_cnt
         $error("at least one timer and one PWM source required");
      end
   endgenerate

   logic             pin_s;
   logic             pin_fall;
   logic             pin_rise;
   logic             raw_trig;
   logic [CFG_W-1:0] cfg_vec;

   assign cfg_vec = {trig_en, src_sel, pin_mode};

   dts_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (ext_pin),
      .q_sync  (pin_s)
   );

   dts_edge #(.CFG_W(CFG_W)) u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .pin_s (pin_s),
      .cfg   (cfg_vec),
      .fall  (pin_fall),
      .rise  (pin_rise)
   );

   dts_mux #(.N_TMR(N_TMR), .N_PWM(N_PWM), .SEL_W(SEL_W)) u_mux (
      .trig_en  (trig_en),
      .src_sel  (src_sel),
      .pin_mode (pin_mode_e'(pin_mode)),
      .pin_s    (pin_s),
      .pin_fall (pin_fall),
      .pin_rise (pin_rise),
      .tmr_evt  (tmr_evt),
      .pwm_evt  (pwm_evt),
      .sw_trig  (sw_trig),
      .dat_wr   (dat_wr),
      .raw_trig (raw_trig)
   );

   // a pending start also blocks, so pulses are always one cycle wide
   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) start_conv <= 1'b0;
      else        start_conv <= raw_trig && !conv_busy && !start_conv;
endmodule

// File: rtl/dts_checker.sv
module dts_checker #(
   parameter int N_TMR = 4,
   parameter int N_PWM = 2,
   parameter int SEL_W = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             trig_en,
   input logic [SEL_W-1:0] src_sel,
   input logic [N_TMR-1:0] tmr_evt,
   input logic [N_PWM-1:0] pwm_evt,
   input logic             sw_trig,
   input logic             dat_wr,
   input logic             conv_busy,
   input logic             start_conv
);
   assert_reset_quiet_R1: assert property (@(posedge clk)
      !rst_n |=> !start_conv);

   assert_data_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!trig_en && dat_wr && !conv_busy && !start_conv) |=> start_conv);

   assert_data_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!trig_en && !dat_wr) |=> !start_conv);

   assert_soft_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_en && src_sel == SEL_W'(0) && !sw_trig) |=> !start_conv);

   assert_timer0_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_en && src_sel == SEL_W'(2) && !tmr_evt[0]) |=> !start_conv);

   assert_pwm0_fires_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_en && src_sel == SEL_W'(2 + N_TMR) && pwm_evt[0]
       && !conv_busy && !start_conv) |=> start_conv);

   assert_busy_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
      conv_busy |=> !start_conv);

   assert_one_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      start_conv |=> !start_conv);
endmodule

bind dac_trig_sel dts_checker #(
   .N_TMR (N_TMR),
   .N_PWM (N_PWM),
   .SEL_W (SEL_W)
) u_dts_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .trig_en    (trig_en),
   .src_sel    (src_sel),
   .tmr_evt    (tmr_evt),
   .pwm_evt    (pwm_evt),
   .sw_trig    (sw_trig),
   .dat_wr     (dat_wr),
   .conv_busy  (conv_busy),
   .start_conv (start_conv)
);

// File: tb/dac_trig_sel_tb_top.sv
module dac_trig_sel_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       trig_en = 1'b0;
   logic [2:0] src_sel = '0;
   logic [1:0] pin_mode = '0;
   logic       ext_pin = 1'b0;
   logic [3:0] tmr_evt = '0;
   logic [1:0] pwm_evt = '0;
   logic       sw_trig = 1'b0;
   logic       dat_wr = 1'b0;
   logic       conv_busy;
   logic       start_conv;

   int    errors = 0;
   int    checks = 0;
   int    pulses = 0;
   int    cycles = 0;
   int    busy_len = 0;
   int    busy_cnt = 0;
   string phase = "R1";
   bit    done = 0;

   always #2 clk = ~clk;

   dac_trig_sel dut_i (
      .clk(clk), .rst_n(rst_n), .trig_en(trig_en), .src_sel(src_sel),
      .pin_mode(pin_mode), .ext_pin(ext_pin), .tmr_evt(tmr_evt),
      .pwm_evt(pwm_evt), .sw_trig(sw_trig), .dat_wr(dat_wr),
      .conv_busy(conv_busy), .start_conv(start_conv)
   );

   // converter stand-in: busy for busy_len cycles after each start
   assign conv_busy = (busy_cnt != 0);
   always @(posedge clk)
      if (busy_len > 0 && start_conv) busy_cnt <= busy_len;
      else if (busy_cnt > 0)          busy_cnt <= busy_cnt - 1;

   // behavioural reference
   int m_q[$];
   int m_prev, m_hist, m_start, m_cfg;
   initial begin m_q = '{0, 0}; m_prev = 0; m_hist = 0; m_start = 0; m_cfg = 0; end

   always @(posedge clk) begin
      int cfg_now, s, go, trig, edge_valid;
      cfg_now = {trig_en, src_sel, pin_mode};
      if (!rst_n) begin
         m_q = '{0, 0}; m_prev = 0; m_hist = 0; m_start = 0; m_cfg = 0;
      end else begin
         s = m_q[1];
         edge_valid = m_hist && (cfg_now == m_cfg);
         trig = 0;
         if (trig_en == 0) trig = dat_wr;
         else if (src_sel == 0) trig = sw_trig;
         else if (src_sel == 1) begin
            if (pin_mode == 0) trig = (s == 0);
            else if (pin_mode == 1) trig = (s == 1);
            else if (pin_mode == 2) trig = edge_valid && m_prev == 1 && s == 0;
            else trig = edge_valid && m_prev == 0 && s == 1;
         end else if (src_sel < 6) trig = tmr_evt[src_sel - 2];
         else trig = pwm_evt[src_sel - 6];
         go = trig && !conv_busy && !m_start;
         m_prev = s;
         void'(m_q.pop_back());
         m_q.push_front(int'(ext_pin));
         m_cfg = cfg_now;
         m_hist = 1;
         m_start = go;
      end
   end

   logic last_start = 1'b0;
   always @(negedge clk) begin
      cycles++;
      if (!done) begin
         checks++;
         if (int'(start_conv) != m_start) begin
            errors++;
            $display("FAIL %s: start_conv=%0d expected %0d at cycle %0d",
                     phase, start_conv, m_start, cycles);
         end
         if (rst_n && last_start && start_conv) begin
            errors++; checks++;
            $display("FAIL R9: start_conv=1 expected 0 after a start (cycle %0d)", cycles);
         end
         if (start_conv) pulses++;
         last_start = start_conv;
      end
   end

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic cfg(bit en, int sel, int mode);
      trig_en = en; src_sel = 3'(sel); pin_mode = 2'(mode);
   endtask

   task automatic pulse_src(int which);
      // 0 sw, 1 dat, 2..5 timers, 6..7 pwm
      if (which == 0) sw_trig = 1'b1;
      else if (which == 1) dat_wr = 1'b1;
      else if (which < 6) tmr_evt[which - 2] = 1'b1;
      else pwm_evt[which - 6] = 1'b1;
      tick(1);
      sw_trig = 0; dat_wr = 0; tmr_evt = '0; pwm_evt = '0;
      tick(3);
   endtask

   initial begin
      int base;
      tick(3);
      phase = "R1";
      chk("R1", int'(start_conv), 0);
      rst_n = 1'b1;
      tick(1);
      chk("R1", int'(start_conv), 0);
      tick(2);

      phase = "R2";
      cfg(0, 3, 1); ext_pin = 1; tick(4);
      base = pulses;
      pulse_src(1);
      chk("R2", pulses - base, 1);
      base = pulses;
      for (int w = 0; w < 8; w++) if (w != 1) pulse_src(w);
      chk("R2", pulses - base, 0);

      phase = "R3";
      cfg(1, 0, 0); tick(2);
      base = pulses; pulse_src(0); chk("R3", pulses - base, 1);
      base = pulses;
      for (int w = 1; w < 8; w++) pulse_src(w);
      chk("R3", pulses - base, 0);

      phase = "R6";
      for (int s = 2; s < 8; s++) begin
         cfg(1, s, 0); tick(2);
         for (int w = 0; w < 8; w++) begin
            base = pulses; pulse_src(w);
            chk("R6", pulses - base, (w == s) ? 1 : 0);
         end
      end

      phase = "R4";
      busy_len = 3;
      cfg(1, 1, 1); ext_pin = 1; tick(20);
      base = pulses; tick(20);
      chk("R4", (pulses - base) >= 3, 1);
      cfg(1, 1, 0); tick(3);
      base = pulses; tick(10);
      chk("R4", pulses - base, 0);
      ext_pin = 0; tick(20);
      chk("R4", (pulses - base) >= 3, 1);
      busy_len = 0;
      cfg(1, 1, 1); tick(10);

      phase = "R5";
      cfg(1, 1, 3); tick(5);
      base = pulses; ext_pin = 1; tick(10);
      chk("R5", pulses - base, 1);
      base = pulses; ext_pin = 0; tick(10);
      chk("R5", pulses - base, 0);
      cfg(1, 1, 2); tick(3);
      base = pulses; ext_pin = 1; tick(10); ext_pin = 0; tick(10);
      chk("R5", pulses - base, 1);

      phase = "R7";
      cfg(1, 1, 3); tick(5);
      ext_pin = 1;
      tick(2); chk("R7", int'(start_conv), 0);
      tick(1); chk("R7", int'(start_conv), 1);
      tick(5); ext_pin = 0; tick(5);

      phase = "R8";
      busy_len = 8;
      cfg(1, 2, 0); tick(3);
      base = pulses;
      tmr_evt[0] = 1; tick(1); tmr_evt[0] = 0;
      tick(3);
      tmr_evt[0] = 1; tick(1); tmr_evt[0] = 0;
      tick(15);
      chk("R8", pulses - base, 1);
      busy_len = 0;

      phase = "R9";
      cfg(1, 1, 0); tick(3);
      base = pulses; tick(20);
      chk("R9", pulses - base, 10);

      phase = "R10";
      cfg(1, 2, 0); ext_pin = 0; tick(6);
      base = pulses;
      ext_pin = 1; tick(2);
      cfg(1, 1, 3); tick(10);
      chk("R10", pulses - base, 0);
      ext_pin = 0; tick(5);

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      tick(20000);
      if (!done) begin
         done = 1;
         errors++; checks++;
         $display("FAIL watchdog: run did not finish, actual hung expected done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule